// File: doc/BRIEF.md
# Reconfiguration Parameter Access Bridge

This block puts a small word-wide parameter interface in front of a bit-serial register port. The register port belongs to the hard logic that picks the next configuration image. User logic names a parameter with a 3-bit select and gives a one-cycle read or write strobe. The bridge then runs the serial sequence on its own, holds `busy` high until the sequence ends, and returns the selected field right-aligned on a 12-bit read bus.

Behind the port sits a 26-bit image. The 5-bit reconfiguration cause occupies bits [4:0]. The remaining 21 bits form the control word:
- bit 5: application-not-factory flag
- bits [12:6]: 7-bit page field
- bit 13: watchdog enable
- bits [25:14]: 12-bit watchdog timeout

A read captures the image and rotates all 26 bits out and back in. A write does the same rotation, patches one field, shifts the new 21-bit word back in and pulses update. Only a factory image may write. The bridge also registers the page value it last wrote, forwards reconfiguration requests only while idle, and passes the watchdog kick straight through.

Top module: `cfg_param_bridge`

## Requirements
- R1: Select codes: 000 = cause (5 bits), 010 = timeout (12 bits), 011 = watchdog enable (1 bit), 100 = page (low `PAGE_W` bits of the page field), 101 = application flag (1 bit). A completed read returns the field zero-extended into `readData`.
- R2: A read or write strobe accepted while idle raises `busy` on the next edge. A legal read holds `busy` for 28 cycles and a legal write for 50. While `busy` is high, strobes, select and write data are ignored. When both strobes arrive together, the read wins.
- R3: A read pulses `regCapture` for one cycle, then `regShift` for 26 cycles with `regDin` equal to `regDout`. `readData` changes only on the edge where `busy` falls.
- R4: A write performs the same capture and rotation, then 21 shift cycles that send the patched control word LSB first with bit 0 forced to 1, then a one-cycle `regUpdate`.
- R5: While `isApp` is high, a write strobe is ignored: `busy` stays low and there is no serial activity.
- R6: Codes 001, 110 and 111, and writes to 000 or 101, keep `busy` high for one cycle with no serial activity. Such a read returns 0.
- R7: `reconfigOut` pulses one cycle after `reconfigReq`, and only when `busy` was low in that cycle.
- R8: `wdKickOut` follows `wdKickIn` combinationally at all times, busy or not.
- R9: Asserting `rst` (asynchronous, active high) returns the bridge to idle at once, even mid-operation. It clears `readData` and `pageOut` and leaves the register image unmodified.
- R10: A completed write to code 100 updates `pageOut` on the edge where `busy` falls.
- R11: `regCapture`, `regShift` and `regUpdate` are mutually exclusive and all low while idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Asynchronous reset, active high |
| readStb | input | 1 | One-cycle read strobe |
| writeStb | input | 1 | One-cycle write strobe |
| paramSel | input | 3 | Parameter select code |
| writeData | input | 12 | Write value, field right-aligned |
| reconfigReq | input | 1 | Request to start reconfiguration |
| wdKickIn | input | 1 | Watchdog reset from user logic |
| isApp | input | 1 | High when an application image is loaded |
| regDout | input | 1 | Serial bit from the register shift chain |
| busy | output | 1 | Operation in progress |
| readData | output | 12 | Last read result |
| pageOut | output | PAGE_W | Page value last written |
| reconfigOut | output | 1 | Forwarded reconfiguration pulse |
| wdKickOut | output | 1 | Forwarded watchdog reset |
| regCapture | output | 1 | Load the shift chain from the registers |
| regShift | output | 1 | Shift the chain one bit toward bit 0 |
| regUpdate | output | 1 | Copy chain bits [25:5] into the update register |
| regDin | output | 1 | Serial bit into the top of the chain |

## Verification
The assertions rely on three conditions:
- reset is high at time zero;
- strobes last one cycle;
- `isApp` changes only while the bridge is idle, so a write that starts in a factory image also ends in one.

The stimulus drives every input on the falling edge. It raises strobes for exactly one cycle and switches `isApp` only between operations. It aims its deliberately noisy strobes, selects and requests only at cycles where `busy` was already high. The serial register image is played by a bench model that captures, rotates and updates the way the port expects, so every field value the bench reads back can be predicted.

// File: rtl/bridgePkg.sv
package bridgePkg;
  localparam int STAT_W = 5;
  localparam int WORD_W = 21;
  localparam int IMG_W  = STAT_W + WORD_W;
  localparam int DATA_W = 12;
  localparam int PG_W   = 7;

  // positions inside the 21-bit control word
  localparam int W_APP  = 0;
  localparam int W_PAGE = 1;
  localparam int W_WDEN = W_PAGE + PG_W;
  localparam int W_TIME = W_WDEN + 1;

  localparam logic [2:0] SEL_CAUSE = 3'b000;
  localparam logic [2:0] SEL_TIME  = 3'b010;
  localparam logic [2:0] SEL_WDEN  = 3'b011;
  localparam logic [2:0] SEL_PAGE  = 3'b100;
  localparam logic [2:0] SEL_APP   = 3'b101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CAP, ST_SOUT, ST_FIN, ST_SIN, ST_UPD, ST_NOP
  } stateT;

  typedef struct packed {
    logic latchCmd;
    logic capture;
    logic shiftOut;
    logic shiftIn;
    logic finish;
    logic update;
    logic clearRd;
    logic opWrite;
  } ctrlStrobeT;
endpackage

// File: rtl/cfg_param_bridge_ctrl.sv
module cfg_param_bridge_ctrl
  import bridgePkg::*;
#(
  parameter int IMG_BITS  = IMG_W,
  parameter int WORD_BITS = WORD_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       readStb,
  input  logic       writeStb,
  input  logic [2:0] paramSel,
  input  logic       isApp,
  output logic       busy,
  output ctrlStrobeT strb
);
  localparam int CNT_W = $clog2(IMG_BITS);

  stateT            state;
  logic [CNT_W-1:0] cnt;
  logic             opWrite;
  logic             rdOk;
  logic             wrOk;

  always_comb begin
    rdOk = (paramSel == SEL_CAUSE) || (paramSel == SEL_TIME) || (paramSel == SEL_WDEN) ||
           (paramSel == SEL_PAGE)  || (paramSel == SEL_APP);
    wrOk = (paramSel == SEL_TIME) || (paramSel == SEL_WDEN) || (paramSel == SEL_PAGE);
  end

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      opWrite <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (readStb) begin
            opWrite <= 1'b0;
            state   <= rdOk ? ST_CAP : ST_NOP;
          end else if (writeStb && !isApp) begin
            opWrite <= 1'b1;
            state   <= wrOk ? ST_CAP : ST_NOP;
          end
        end
        ST_CAP:  state <= ST_SOUT;
        ST_SOUT: begin
          if (cnt == CNT_W'(IMG_BITS - 1)) begin
            cnt   <= '0;
            state <= ST_FIN;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_FIN:  state <= opWrite ? ST_SIN : ST_IDLE;
        ST_SIN: begin
          if (cnt == CNT_W'(WORD_BITS - 1)) begin
            cnt   <= '0;
            state <= ST_UPD;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busy          = (state != ST_IDLE);
    strb.latchCmd = (state == ST_IDLE) && (readStb || (writeStb && !isApp));
    strb.capture  = (state == ST_CAP);
    strb.shiftOut = (state == ST_SOUT);
    strb.shiftIn  = (state == ST_SIN);
    strb.finish   = (state == ST_FIN);
    strb.update   = (state == ST_UPD);
    strb.clearRd  = (state == ST_NOP) && !opWrite;
    strb.opWrite  = opWrite;
  end
endmodule

// File: rtl/cfg_param_bridge_dp.sv
module cfg_param_bridge_dp
  import bridgePkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  ctrlStrobeT        strb,
  input  logic [2:0]        paramSel,
  input  logic [DATA_W-1:0] writeData,
  input  logic              regDout,
  output logic              regDin,
  output logic [DATA_W-1:0] readData,
  output logic [PAGE_W-1:0] pageOut
);
  localparam int I_APP  = STAT_W + W_APP;
  localparam int I_PAGE = STAT_W + W_PAGE;
  localparam int I_WDEN = STAT_W + W_WDEN;
  localparam int I_TIME = STAT_W + W_TIME;

  logic [2:0]        selQ;
  logic [DATA_W-1:0] dataQ;
  logic [IMG_W-1:0]  acc;
  logic [WORD_W-1:0] wordOut;
  logic [WORD_W-1:0] modWord;
  logic [DATA_W-1:0] fieldVal;

  always_comb begin
    modWord = acc[IMG_W-1:STAT_W];
    case (selQ)
      SEL_TIME: modWord[W_TIME +: DATA_W] = dataQ;
      SEL_WDEN: modWord[W_WDEN]           = dataQ[0];
      SEL_PAGE: modWord[W_PAGE +: PAGE_W] = dataQ[PAGE_W-1:0];
      default:  ;
    endcase
    modWord[W_APP] = 1'b1;
  end

  always_comb begin
    case (selQ)
      SEL_CAUSE: fieldVal = DATA_W'(acc[STAT_W-1:0]);
      SEL_TIME:  fieldVal = acc[I_TIME +: DATA_W];
      SEL_WDEN:  fieldVal = DATA_W'(acc[I_WDEN]);
      SEL_PAGE:  fieldVal = DATA_W'(acc[I_PAGE +: PAGE_W]);
      SEL_APP:   fieldVal = DATA_W'(acc[I_APP]);
      default:   fieldVal = '0;
    endcase
  end

  assign regDin = strb.shiftIn ? wordOut[0] : regDout;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      selQ     <= '0;
      dataQ    <= '0;
      acc      <= '0;
      wordOut  <= '0;
      readData <= '0;
      pageOut  <= '0;
    end else begin
      if (strb.latchCmd) begin
        selQ  <= paramSel;
        dataQ <= writeData;
      end
      if (strb.shiftOut) acc <= {regDout, acc[IMG_W-1:1]};
      if (strb.finish) begin
        if (strb.opWrite) wordOut  <= modWord;
        else              readData <= fieldVal;
      end
      if (strb.shiftIn) wordOut <= {1'b0, wordOut[WORD_W-1:1]};
      if (strb.update && selQ == SEL_PAGE) pageOut <= dataQ[PAGE_W-1:0];
      if (strb.clearRd) readData <= '0;
    end
  end
endmodule

// File: rtl/cfg_param_bridge.sv
module cfg_param_bridge
  import bridgePkg::*;
#(
  parameter int PAGE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              readStb,
  input  logic              writeStb,
  input  logic [2:0]        paramSel,
  input  logic [DATA_W-1:0] writeData,
  input  logic              reconfigReq,
  input  logic              wdKickIn,
  input  logic              isApp,
  input  logic              regDout,
  output logic              busy,
  output logic [DATA_W-1:0] readData,
  output logic [PAGE_W-1:0] pageOut,
  output logic              reconfigOut,
  output logic              wdKickOut,
  output logic              regCapture,
  output logic              regShift,
  output logic              regUpdate,
  output logic              regDin
);
  ctrlStrobeT strb;

  cfg_param_bridge_ctrl #(.IMG_BITS(IMG_W), .WORD_BITS(WORD_W)) u_ctrl (
    .clk(clk), .rst(rst), .readStb(readStb), .writeStb(writeStb),
    .paramSel(paramSel), .isApp(isApp), .busy(busy), .strb(strb)
  );

  cfg_param_bridge_dp #(.PAGE_W(PAGE_W)) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .paramSel(paramSel),
    .writeData(writeData), .regDout(regDout), .regDin(regDin),
    .readData(readData), .pageOut(pageOut)
  );

  assign regCapture = strb.capture;
  assign regShift   = strb.shiftOut | strb.shiftIn;
  assign regUpdate  = strb.update;
  assign wdKickOut  = wdKickIn;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) reconfigOut <= 1'b0;
    else     reconfigOut <= reconfigReq && !busy;
  end
endmodule

// File: rtl/cfg_param_bridge_chk.sv
module cfg_param_bridge_chk (
  input logic        clk,
  input logic        rst,
  input logic        readStb,
  input logic        writeStb,
  input logic        isApp,
  input logic        busy,
  input logic [11:0] readData,
  input logic        reconfigOut,
  input logic        regCapture,
  input logic        regShift,
  input logic        regUpdate
);
  AST_BUSY_ON_READ: assert property (@(posedge clk) disable iff (rst) (!busy && readStb) |=> busy); // R2
  AST_APP_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst) (!busy && isApp && writeStb && !readStb) |=> !busy); // R5
  AST_RECONF_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst) reconfigOut |-> $past(!busy)); // R7
  AST_SERIAL_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) $onehot0({regCapture, regShift, regUpdate})); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) !busy |-> !(regCapture || regShift || regUpdate)); // R11
  AST_READ_DATA_HOLD: assert property (@(posedge clk) disable iff (rst) !$stable(readData) |-> $fell(busy)); // R3
  AST_UPDATE_ENDS_OP: assert property (@(posedge clk) disable iff (rst) regUpdate |=> !busy); // R4
endmodule

bind cfg_param_bridge cfg_param_bridge_chk u_chk (
  .clk(clk), .rst(rst), .readStb(readStb), .writeStb(writeStb), .isApp(isApp),
  .busy(busy), .readData(readData), .reconfigOut(reconfigOut),
  .regCapture(regCapture), .regShift(regShift), .regUpdate(regUpdate)
);

// File: tb/cfg_param_bridge_tb.sv
module cfg_param_bridge_tb;
  localparam int PW = 3;
  localparam logic [20:0] CTRL_INIT = {12'hA5C, 1'b1, 7'd5, 1'b1};
  localparam logic [20:0] UPD_INIT  = {12'h123, 1'b0, 7'd2, 1'b0};
  localparam logic [4:0]  STAT_INIT = 5'b10110;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic readStb = 0, writeStb = 0, reconfigReq = 0, wdKickIn = 0, isApp = 0;
  logic [2:0]  paramSel = 0;
  logic [11:0] writeData = 0;
  logic regDout, busy, reconfigOut, wdKickOut, regCapture, regShift, regUpdate, regDin;
  logic [11:0] readData;
  logic [PW-1:0] pageOut;

  cfg_param_bridge #(.PAGE_W(PW)) u_dut (
    .clk(clk), .rst(rst), .readStb(readStb), .writeStb(writeStb), .paramSel(paramSel),
    .writeData(writeData), .reconfigReq(reconfigReq), .wdKickIn(wdKickIn), .isApp(isApp),
    .regDout(regDout), .busy(busy), .readData(readData), .pageOut(pageOut),
    .reconfigOut(reconfigOut), .wdKickOut(wdKickOut), .regCapture(regCapture),
    .regShift(regShift), .regUpdate(regUpdate), .regDin(regDin)
  );

  // serial register image played by the bench
  logic [25:0] sr = '0;
  logic [20:0] ctrlW = CTRL_INIT;
  logic [20:0] updW = UPD_INIT;
  logic [4:0]  statV = STAT_INIT;
  assign regDout = sr[0];
  always @(posedge clk) begin
    if (regCapture)    sr <= {(isApp ? ctrlW : updW), statV};
    else if (regShift) sr <= {regDin, sr[25:1]};
    if (regUpdate)     updW <= sr[25:5];
  end

  int nChk = 0, nFail = 0, cyc = 0;
  bit started = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit readLegal(input logic [2:0] s);
    return s inside {3'b000, 3'b010, 3'b011, 3'b100, 3'b101};
  endfunction
  function automatic bit writeLegal(input logic [2:0] s);
    return s inside {3'b010, 3'b011, 3'b100};
  endfunction
  function automatic logic [11:0] fieldOf(input logic [25:0] img, input logic [2:0] s);
    case (s)
      3'b000:  return {7'b0, img[4:0]};
      3'b010:  return img[25:14];
      3'b011:  return {11'b0, img[13]};
      3'b100:  return 12'(img[6 +: PW]);
      3'b101:  return {11'b0, img[5]};
      default: return 12'h0;
    endcase
  endfunction
  function automatic logic [20:0] modOf(input logic [20:0] w, input logic [2:0] s, input logic [11:0] d);
    logic [20:0] r = w;
    if (s == 3'b010) r[20:9] = d;
    if (s == 3'b011) r[8] = d[0];
    if (s == 3'b100) r[1 +: PW] = d[PW-1:0];
    r[0] = 1'b1;
    return r;
  endfunction

  // cycle reference model
  int mK = -1, mLen = 1;
  logic mWrite = 0, mLegal = 0, mRecfg = 0;
  logic [11:0] mPend = 0, mRd = 0, mData = 0;
  logic [2:0]  mSel = 0;
  logic [PW-1:0] mPage = 0;
  logic [20:0] mExpW = 0;
  logic [20:0] mExpUpd = UPD_INIT;

  always @(posedge clk or posedge rst) begin
    if (rst) begin
      mK <= -1; mRd <= 0; mPage <= 0; mRecfg <= 0; mLegal <= 0; mWrite <= 0;
    end else begin
      mRecfg <= reconfigReq && (mK == -1);
      if (mK == -1) begin
        if (readStb) begin
          mWrite <= 0; mLegal <= readLegal(paramSel);
          mLen   <= readLegal(paramSel) ? 28 : 1;
          mPend  <= readLegal(paramSel) ? fieldOf({(isApp ? ctrlW : updW), statV}, paramSel) : 12'h0;
          mK     <= 0;
        end else if (writeStb && !isApp) begin
          mWrite <= 1; mLegal <= writeLegal(paramSel);
          mLen   <= writeLegal(paramSel) ? 50 : 1;
          mSel   <= paramSel; mData <= writeData;
          mExpW  <= modOf(updW, paramSel, writeData);
          mK     <= 0;
        end
      end else if (mK == mLen - 1) begin
        mK <= -1;
        if (!mWrite) mRd <= mPend;
        else if (mLegal) begin
          mExpUpd <= mExpW;
          if (mSel == 3'b100) mPage <= mData[PW-1:0];
        end
      end else begin
        mK <= mK + 1;
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      check("R2 busy", busy, mK != -1);
      check("R1 R3 readData", readData, mRd);
      check("R10 pageOut", pageOut, mPage);
      check("R7 reconfigOut", reconfigOut, mRecfg);
      check("R3 capture", regCapture, mLegal && mK == 0);
      check("R4 shift", regShift, mLegal && ((mK >= 1 && mK <= 26) || (mWrite && mK >= 28 && mK <= 48)));
      check("R4 update", regUpdate, mLegal && mWrite && mK == 49);
      check("R4 written word", updW, mExpUpd);
      check("R11 exclusive", (regCapture + regShift + regUpdate) <= 1, 1);
      if (regShift && mK <= 26) check("R3 recirculate", regDin, regDout);
    end
  end

  task automatic finish();
    $display("%0d/%0d checks passed", nChk - nFail, nChk);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nChk++; nFail++;
      $display("FAIL R2 watchdog actual=busy expected=idle");
      finish();
    end
  end

  task automatic waitIdle(input bit junk);
    int g = 0;
    @(negedge clk);
    readStb = 0; writeStb = 0;
    while (busy && g < 200) begin
      if (junk) begin
        paramSel    = 3'($urandom % 8);
        writeData   = 12'($urandom);
        readStb     = 1'($urandom % 2);
        writeStb    = 1'($urandom % 2);
        reconfigReq = 1'($urandom % 2);
        wdKickIn    = 1'($urandom % 2);
        #1 check("R8 wdKick", wdKickOut, wdKickIn);
      end
      @(negedge clk);
      readStb = 0; writeStb = 0; reconfigReq = 0;
      g++;
    end
  endtask

  task automatic op(input bit rd, input logic [2:0] s, input logic [11:0] d, input bit junk);
    readStb = rd; writeStb = !rd; paramSel = s; writeData = d;
    waitIdle(junk);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    started = 1;
    check("R9 reset busy", busy, 0);
    check("R9 reset readData", readData, 0);
    check("R9 reset pageOut", pageOut, 0);
    rst = 0;
    @(negedge clk);

    // factory reads, initial update-register contents
    op(1, 3'b000, 0, 0); check("R1 cause", readData, 12'h016);
    op(1, 3'b010, 0, 1); check("R1 timeout", readData, 12'h123);
    op(1, 3'b011, 0, 0); check("R1 wd enable", readData, 12'h000);
    op(1, 3'b100, 0, 0); check("R1 page", readData, 12'h002);
    op(1, 3'b101, 0, 0); check("R1 app flag", readData, 12'h000);

    // factory writes and readback
    op(0, 3'b010, 12'hBEE, 1);
    op(0, 3'b011, 12'h001, 0);
    op(0, 3'b100, 12'h005, 1);
    check("R10 page forwarded", pageOut, 3'd5);
    op(1, 3'b010, 0, 0); check("R4 timeout readback", readData, 12'hBEE);
    op(1, 3'b011, 0, 0); check("R4 enable readback", readData, 12'h001);
    op(1, 3'b100, 0, 0); check("R4 page readback", readData, 12'h005);
    op(1, 3'b101, 0, 0); check("R4 flag forced", readData, 12'h001);

    // illegal codes and read-only writes
    readStb = 1; paramSel = 3'b110;
    @(negedge clk); readStb = 0;
    check("R6 one-cycle busy", busy, 1);
    @(negedge clk);
    check("R6 done", busy, 0);
    check("R6 zero data", readData, 0);
    op(1, 3'b001, 0, 0); op(1, 3'b111, 0, 0);
    op(0, 3'b000, 12'hFFF, 0); op(0, 3'b101, 12'h000, 0); op(0, 3'b001, 12'h7, 0);
    op(1, 3'b011, 0, 0); check("R6 no side effect", readData, 12'h001);

    // reconfiguration gating
    reconfigReq = 1; @(negedge clk); reconfigReq = 0;
    check("R7 idle request", reconfigOut, 1);
    readStb = 1; paramSel = 3'b010; @(negedge clk); readStb = 0;
    reconfigReq = 1; @(negedge clk); reconfigReq = 0;
    check("R7 busy request dropped", reconfigOut, 0);
    waitIdle(0);
    wdKickIn = 1; #1 check("R8 kick high", wdKickOut, 1);
    wdKickIn = 0; #1 check("R8 kick low", wdKickOut, 0);

    // application image: writes ignored, reads see control register
    isApp = 1;
    @(negedge clk);
    writeStb = 1; paramSel = 3'b010; writeData = 12'h000;
    @(negedge clk); writeStb = 0;
    check("R5 no busy", busy, 0);
    check("R5 no serial", regCapture | regShift | regUpdate, 0);
    @(negedge clk);
    op(1, 3'b010, 0, 0); check("R1 app timeout", readData, 12'hA5C);
    op(1, 3'b100, 0, 0); check("R1 app page", readData, 12'h005);
    op(1, 3'b101, 0, 0); check("R1 app flag", readData, 12'h001);
    isApp = 0;
    @(negedge clk);

    // reset in the middle of a write
    writeStb = 1; paramSel = 3'b010; writeData = 12'h777;
    @(negedge clk); writeStb = 0;
    repeat (30) @(negedge clk);
    rst = 1;
    #1 check("R9 async idle", busy, 0);
    check("R9 async serial", regShift, 0);
    repeat (2) @(negedge clk);
    rst = 0;
    @(negedge clk);
    op(1, 3'b010, 0, 0); check("R9 image intact", readData, 12'hBEE);

    // mixed traffic
    for (int i = 0; i < 40; i++) begin
      op(1'($urandom % 2), 3'($urandom % 8), 12'($urandom), 1);
    end
    repeat (3) @(negedge clk);
    finish();
  end
endmodule